// File: doc/BRIEF.md
# Double-Buffered Clock Register Window

This block places a set of eight timekeeping registers at the very top of a byte-wide address space. A host reads and writes them exactly like memory bytes. Every access whose address lies below that eight-byte window is handed unchanged to a RAM port. The registers the host sees are a user copy: a buffer that stands between the host and a separate chain of running time counters. Without a halt, the copy follows the counters at each tick strobe.

The lowest byte of the window is a control byte with two halt flags. The read flag freezes the copy, so the host can read a consistent snapshot while the counters keep running. The write flag also freezes the copy, and lets the host load new calendar values into it. When the write flag is cleared, the loaded image is pushed to the counter chain through a one-cycle load strobe, and normal following resumes.

The counter chain and the RAM array lie outside this block. The counters report their present value on a parallel input, and they take a new value from a parallel output whenever the load strobe is high.

Top module: `rtc_shadow_window`

## Requirements
- R1: The window is the eight highest addresses (all upper address bits set). Byte offset 0 is control, then 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month and 7 year. On the parallel counter input and load output, the byte of offset k sits at bits [8k-1:8k-8].
- R2: Control bit 7 is the write flag and bit 6 is the read flag. Bits 5..0 of the control byte have no storage and always read as 0.
- R3: While the read flag is 1, tick strobes leave the user copy unchanged, so reads return the values captured before the flag was set.
- R4: While a halt is in effect, host writes to the time bytes never reach the counter port: the load strobe stays low.
- R5: While the write flag is 1, tick strobes do not change the copy, and host writes to time bytes are stored and read back.
- R6: A control write that clears a set write flag raises the load strobe for exactly the next cycle, with the load output equal to the copy at that moment.
- R7: After the read flag is cleared, the copy keeps its frozen values until the next tick strobe, which refreshes it.
- R8: Each byte keeps only its meaningful bits. The masks are: seconds 0xFF (bit 7 is the oscillator stop flag), minutes 0x7F, hours 0x3F, weekday 0x47 (bit 6 is the frequency test flag), day of month 0x3F, month 0x1F and year 0xFF. Masked-off bits read as 0 after both host writes and refreshes.
- R9: With neither flag set, one tick strobe reloads all seven time bytes from the counter input in the same cycle.
- R10: If both flags are set and only the write flag is then cleared, the load strobe still fires, and the copy stays frozen until the read flag is cleared too.
- R11: An access below the window drives the RAM port with the same address, data, write and read enables, and returns the RAM read data. An access inside the window keeps both RAM enables low.
- R12: A tick strobe in the cycle when the load strobe is high is ignored, so stale counter values cannot overwrite the copy being loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | ADDR_W | Host byte address |
| hostWe | input | 1 | Host write enable |
| hostRe | input | 1 | Host read enable |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data (combinational) |
| ramAddr | output | ADDR_W | Address forwarded to RAM |
| ramWe | output | 1 | RAM write enable |
| ramRe | output | 1 | RAM read enable |
| ramWdata | output | 8 | Data forwarded to RAM |
| ramRdata | input | 8 | Read data returned by RAM |
| tickStb | input | 1 | Counter chain has advanced |
| cntTime | input | 56 | Present counter value, seven bytes |
| loadStb | output | 1 | Load the counters from loadTime |
| loadTime | output | 56 | Image to load into the counters |

## Verification
Counter values with their unused bits set separate correct masking from plain copying. A tick under each halt state (none, read only, write only, both) separates following from freezing. Clearing the write flag with a tick in the very next cycle shows whether the stale-tick guard works and whether the load pulse carries the host image. Accesses below and inside the window show whether RAM forwarding is gated by the window decode.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int TIME_W   = (NUM_REGS - 1) * BYTE_W;

  localparam logic [IDX_W-1:0] IDX_CTRL = 3'd0;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             refresh;
    logic             transfer;
  } winStb_t;

  function automatic logic [BYTE_W-1:0] fieldMask(input logic [IDX_W-1:0] idx);
    logic [BYTE_W-1:0] m;
    case (idx)
      3'd0:    m = 8'hC0;
      3'd1:    m = 8'hFF;
      3'd2:    m = 8'h7F;
      3'd3:    m = 8'h3F;
      3'd4:    m = 8'h47;
      3'd5:    m = 8'h3F;
      3'd6:    m = 8'h1F;
      default: m = 8'hFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/rtcw_ctrl.sv
module rtcw_ctrl
  import rtcw_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  input  logic              hostRe,
  input  logic [1:0]        ctrlBits,
  input  logic              tickStb,
  output winStb_t           stb,
  output logic [BYTE_W-1:0] ctrlByte,
  output logic              inWin,
  output logic              ramWe,
  output logic              ramRe
);
  logic             wBitQ;
  logic             rBitQ;
  logic             xferPendQ;
  logic [IDX_W-1:0] idx;
  logic             ctrlWr;

  assign inWin  = &hostAddr[ADDR_W-1:IDX_W];
  assign idx    = hostAddr[IDX_W-1:0];
  assign ctrlWr = hostWe && inWin && (idx == IDX_CTRL);
  assign ramWe  = hostWe && !inWin;
  assign ramRe  = hostRe && !inWin;

  always_comb begin
    stb.wrEn     = hostWe && inWin && (idx != IDX_CTRL);
    stb.wrIdx    = idx;
    stb.transfer = ctrlWr && wBitQ && !ctrlBits[1];
    stb.refresh  = tickStb && !wBitQ && !rBitQ && !xferPendQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wBitQ     <= 1'b0;
      rBitQ     <= 1'b0;
      xferPendQ <= 1'b0;
    end else begin
      if (ctrlWr) begin
        wBitQ <= ctrlBits[1];
        rBitQ <= ctrlBits[0];
      end
      xferPendQ <= stb.transfer;
    end
  end

  assign ctrlByte = {wBitQ, rBitQ, 6'b0};

  AST_XFER_CLEARS_W: assert property (@(posedge clk) disable iff (!rstN)
    stb.transfer |=> !wBitQ); // R6
  AST_HALT_BLOCKS_REFRESH: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte[7] || ctrlByte[6]) |-> !stb.refresh); // R3
endmodule

// File: rtl/rtcw_dpath.sv
module rtcw_dpath
  import rtcw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  winStb_t           stb,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [BYTE_W-1:0] ctrlByte,
  input  logic [TIME_W-1:0] cntTime,
  output logic [BYTE_W-1:0] winRdata,
  output logic              loadStb,
  output logic [TIME_W-1:0] loadTime
);
  logic [BYTE_W-1:0] copyQ [1:NUM_REGS-1];
  logic [TIME_W-1:0] copyFlat;
  logic [TIME_W-1:0] maskedCnt;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    localparam logic [BYTE_W-1:0] MY_MASK = fieldMask(MY_IDX);

    assign maskedCnt[(g-1)*BYTE_W +: BYTE_W] = cntTime[(g-1)*BYTE_W +: BYTE_W] & MY_MASK;
    assign copyFlat[(g-1)*BYTE_W +: BYTE_W]  = copyQ[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        copyQ[g] <= '0;
      end else if (stb.wrEn && (stb.wrIdx == MY_IDX)) begin
        copyQ[g] <= wdata & MY_MASK;
      end else if (stb.refresh) begin
        copyQ[g] <= maskedCnt[(g-1)*BYTE_W +: BYTE_W];
      end
    end

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (copyQ[g] & ~MY_MASK) == '0); // R8
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadStb  <= 1'b0;
      loadTime <= '0;
    end else begin
      loadStb <= stb.transfer;
      if (stb.transfer) loadTime <= copyFlat;
    end
  end

  always_comb begin
    winRdata = ctrlByte;
    for (int i = 1; i < NUM_REGS; i++) begin
      if (rdIdx == IDX_W'(i)) winRdata = copyQ[i];
    end
  end

  AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.refresh && !stb.wrEn) |=> $stable(copyFlat)); // R3
  AST_LOAD_IMAGE: assert property (@(posedge clk) disable iff (!rstN)
    stb.transfer |=> (loadStb && loadTime == $past(copyFlat))); // R6
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> !loadStb); // R6
  AST_REFRESH_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (stb.refresh && !stb.wrEn) |=> copyFlat == $past(maskedCnt)); // R9
endmodule

// File: rtl/rtc_shadow_window.sv
module rtc_shadow_window
  import rtcw_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  input  logic              hostRe,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic              ramRe,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata,
  input  logic              tickStb,
  input  logic [55:0]       cntTime,
  output logic              loadStb,
  output logic [55:0]       loadTime
);
  winStb_t           stb;
  logic [BYTE_W-1:0] ctrlByte;
  logic [BYTE_W-1:0] winRdata;
  logic              inWin;

  rtcw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostAddr (hostAddr),
    .hostWe   (hostWe),
    .hostRe   (hostRe),
    .ctrlBits (hostWdata[7:6]),
    .tickStb  (tickStb),
    .stb      (stb),
    .ctrlByte (ctrlByte),
    .inWin    (inWin),
    .ramWe    (ramWe),
    .ramRe    (ramRe)
  );

  rtcw_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wdata    (hostWdata),
    .rdIdx    (hostAddr[IDX_W-1:0]),
    .ctrlByte (ctrlByte),
    .cntTime  (cntTime),
    .winRdata (winRdata),
    .loadStb  (loadStb),
    .loadTime (loadTime)
  );

  assign ramAddr   = hostAddr;
  assign ramWdata  = hostWdata;
  assign hostRdata = inWin ? winRdata : ramRdata;

  AST_WINDOW_NO_RAM: assert property (@(posedge clk) disable iff (!rstN)
    (&hostAddr[ADDR_W-1:3]) |-> (!ramWe && !ramRe)); // R11
endmodule

// File: tb/sim_rtc_shadow_window.sv
module sim_rtc_shadow_window;
  localparam int CLK_PERIOD = 10;
  localparam logic [16:0] WIN = 17'h1FFF8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [16:0] hostAddr = '0;
  logic        hostWe = 1'b0, hostRe = 1'b0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic [16:0] ramAddr;
  logic        ramWe, ramRe;
  logic [7:0]  ramWdata;
  logic [7:0]  ramRdata = '0;
  logic        tickStb = 1'b0;
  logic [55:0] cntTime = '0;
  logic        loadStb;
  logic [55:0] loadTime;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_shadow_window u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWe(hostWe), .hostRe(hostRe),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .ramAddr(ramAddr), .ramWe(ramWe),
    .ramRe(ramRe), .ramWdata(ramWdata), .ramRdata(ramRdata), .tickStb(tickStb),
    .cntTime(cntTime), .loadStb(loadStb), .loadTime(loadTime)
  );

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input int off, input logic [7:0] d);
    @(negedge clk);
    hostAddr = WIN + 17'(off); hostWe = 1'b1; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic rdChk(input string req, input int off, input logic [7:0] exp);
    hostAddr = WIN + 17'(off); hostRe = 1'b1;
    #1;
    chk(req, $sformatf("read offset %0d", off), 64'(hostRdata), 64'(exp));
    hostRe = 1'b0;
  endtask

  task automatic tick(input logic [55:0] t);
    @(negedge clk);
    cntTime = t; tickStb = 1'b1;
    @(negedge clk);
    tickStb = 1'b0;
  endtask

  task automatic testReset;
    rdChk("R2", 0, 8'h00);
    rdChk("R1", 1, 8'h00);
    chk("R6", "loadStb after reset", 64'(loadStb), 64'd0);
  endtask

  task automatic testRefresh;
    tick({8'h24, 8'hE9, 8'h31, 8'hF5, 8'h23, 8'hD9, 8'h07});
    rdChk("R9", 1, 8'h07);
    rdChk("R8", 2, 8'h59);
    rdChk("R1", 3, 8'h23);
    rdChk("R8", 4, 8'h45);
    rdChk("R1", 5, 8'h31);
    rdChk("R8", 6, 8'h09);
    rdChk("R1", 7, 8'h24);
  endtask

  task automatic testReadHalt;
    wr(0, 8'h40);
    rdChk("R2", 0, 8'h40);
    tick({8'h25, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h08});
    rdChk("R3", 1, 8'h07);
    rdChk("R3", 7, 8'h24);
    chk("R4", "no load during read halt", 64'(loadStb), 64'd0);
    wr(0, 8'h00);
    chk("R4", "no load on read clear", 64'(loadStb), 64'd0);
    rdChk("R7", 1, 8'h07);
    tick({8'h25, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h08});
    rdChk("R7", 1, 8'h08);
    rdChk("R7", 7, 8'h25);
  endtask

  task automatic testWriteHalt;
    wr(0, 8'h80);
    wr(1, 8'h25);
    wr(4, 8'hC3);
    wr(7, 8'h99);
    tick({8'h30, 8'h02, 8'h02, 8'h02, 8'h01, 8'h01, 8'h09});
    rdChk("R5", 1, 8'h25);
    rdChk("R8", 4, 8'h43);
    rdChk("R5", 7, 8'h99);
    chk("R4", "no load while write halted", 64'(loadStb), 64'd0);
    @(negedge clk);
    hostAddr = WIN; hostWe = 1'b1; hostWdata = 8'h00;
    @(negedge clk);
    hostWe = 1'b0; tickStb = 1'b1;
    #1;
    chk("R6", "load pulse", 64'(loadStb), 64'd1);
    chk("R6", "load seconds", 64'(loadTime[7:0]), 64'h25);
    chk("R6", "load weekday", 64'(loadTime[31:24]), 64'h43);
    chk("R6", "load year", 64'(loadTime[55:48]), 64'h99);
    @(negedge clk);
    tickStb = 1'b0;
    #1;
    chk("R6", "load pulse ends", 64'(loadStb), 64'd0);
    rdChk("R12", 1, 8'h25);
    tick({8'h30, 8'h02, 8'h02, 8'h02, 8'h01, 8'h01, 8'h09});
    rdChk("R9", 1, 8'h09);
  endtask

  task automatic testBoth;
    wr(0, 8'hC0);
    wr(2, 8'h33);
    wr(0, 8'h40);
    #1;
    chk("R10", "load with read still set", 64'(loadStb), 64'd1);
    chk("R10", "load minutes", 64'(loadTime[15:8]), 64'h33);
    tick({8'h30, 8'h02, 8'h02, 8'h02, 8'h01, 8'h44, 8'h10});
    rdChk("R10", 2, 8'h33);
    wr(0, 8'h00);
    tick({8'h30, 8'h02, 8'h02, 8'h02, 8'h01, 8'h44, 8'h10});
    rdChk("R10", 2, 8'h44);
  endtask

  task automatic testCtrlUnused;
    wr(0, 8'h3F);
    rdChk("R2", 0, 8'h00);
    wr(0, 8'h7F);
    rdChk("R2", 0, 8'h40);
    wr(0, 8'h00);
    chk("R2", "no load from read-only clear", 64'(loadStb), 64'd0);
  endtask

  task automatic testRam;
    @(negedge clk);
    hostAddr = 17'h00123; hostWe = 1'b1; hostWdata = 8'hA5; ramRdata = 8'h5A;
    #1;
    chk("R11", "ramWe below window", 64'(ramWe), 64'd1);
    chk("R11", "ramAddr", 64'(ramAddr), 64'h123);
    chk("R11", "ramWdata", 64'(ramWdata), 64'hA5);
    chk("R11", "RAM read data", 64'(hostRdata), 64'h5A);
    @(negedge clk);
    hostWe = 1'b0; hostRe = 1'b1;
    #1;
    chk("R11", "ramRe below window", 64'(ramRe), 64'd1);
    hostAddr = WIN + 17'd1;
    #1;
    chk("R11", "ramRe in window", 64'(ramRe), 64'd0);
    hostRe = 1'b0; hostWe = 1'b1; hostWdata = 8'h11;
    #1;
    chk("R11", "ramWe in window", 64'(ramWe), 64'd0);
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRefresh();
    testReadHalt();
    testWriteHalt();
    testBoth();
    testCtrlUnused();
    testRam();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule